// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a bus requester and a backing memory. It answers a 32 MB alias window in which each 32-bit word stands for one bit of the backing region. Reading an alias word returns the backing bit as 0 or 1. Writing an alias word sets or clears that bit with a locked read-modify-write on the backing memory, and all other backing bits are left untouched.

The backing base address is a parameter. The alias offset is taken from the low 25 bits of the request address, so the same block can sit behind any alias window. The requester holds a request until the bridge gives a one-cycle ready pulse. The backing port uses a held request with a one-cycle ready pulse, and returns or takes data right-justified for the access size in little-endian lane order.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and after it is released, the bridge is idle with `m_req` low and `s_ready` low until a request arrives.
- R2: With alias offset `off = s_addr[24:0]`, the backing address is `BASE | (off >> 5)` for a byte access (`s_size` = 0), and the bit index is `off[4:2]`.
- R3: For a halfword access (`s_size` = 1) the backing address has bit 0 cleared, and the bit index is `off[5:2]`.
- R4: For a word access (`s_size` = 2, or 3, which is treated as word) the backing address has bits [1:0] cleared, and the bit index is `off[6:2]`.
- R5: A read (`s_write` = 0) returns `s_rdata` = 1 when the selected backing bit is set and 0 when it is clear. Bits [31:1] are always zero.
- R6: A write with `s_wdata[0]` = 1 sets the selected backing bit and leaves every other backing bit unchanged.
- R7: A write with `s_wdata[0]` = 0 clears the selected backing bit and leaves every other backing bit unchanged.
- R8: A write issues exactly one backing read and then exactly one backing write to the same address, back to back. `s_ready` stays low until the write-back is acknowledged.
- R9: A read issues exactly one backing read and no backing write.
- R10: Once raised, `m_req`, `m_addr` and `m_write` are held stable until `m_ready` is seen.
- R11: `s_ready` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Requester access request, held until `s_ready` |
| s_write | input | 1 | 1 = write alias word, 0 = read |
| s_addr | input | 32 | Alias address; bits [24:0] are the offset |
| s_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result (0 or 1), valid with `s_ready` |
| m_req | output | 1 | Backing request, held until `m_ready` |
| m_write | output | 1 | Backing write when 1 |
| m_addr | output | 32 | Backing byte address |
| m_size | output | 2 | Backing access size (0, 1, 2) |
| m_wdata | output | 32 | Backing write data, right-justified |
| m_ready | input | 1 | Backing acknowledge pulse |
| m_rdata | input | 32 | Backing read data, valid with `m_ready` |

## Verification
The bench sweeps every bit of several bytes, halfwords and words through set, read and clear. After each write it compares the whole backing model, so a wrong bit index, a missing alignment, or a byte-lane swap shows up as a disturbed neighbour or an untouched target. The highest alias offset in the window probes the address shift and the base OR: a wrong shift or a dropped base bit gives the wrong `m_addr`. Per-operation counts of backing reads and writes catch a bridge that skips the fetch, writes on a read, or retargets the write-back. Added backing wait states catch a bridge that drops its request or finishes early.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } bb_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_STORE = 2'd2,
    ST_DONE  = 2'd3
  } bb_state_e;
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_BITS = 25,
  parameter int          SHIFT    = 5,
  parameter int          IDX_W    = 5,
  parameter logic [31:0] BASE     = 32'h2000_0000
) (
  input  logic [WIN_BITS-1:0] offset,
  input  bb_size_e            size,
  output logic [ADDR_W-1:0]   baddr,
  output logic [IDX_W-1:0]    bidx
);
  localparam int RAW_W = WIN_BITS - SHIFT;

  logic [RAW_W-1:0]  shifted;
  logic [ADDR_W-1:0] raw;

  assign shifted = offset[WIN_BITS-1:SHIFT];
  assign raw     = ADDR_W'(BASE) | ADDR_W'(shifted);

  always_comb begin
    unique case (size)
      SZ_BYTE: begin
        baddr = raw;
        bidx  = IDX_W'(offset[4:2]);
      end
      SZ_HALF: begin
        baddr = {raw[ADDR_W-1:1], 1'b0};
        bidx  = IDX_W'(offset[5:2]);
      end
      default: begin
        baddr = {raw[ADDR_W-1:2], 2'b00};
        bidx  = offset[6:2];
      end
    endcase
  end
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [IDX_W-1:0]  idx,
  input  logic              set_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] merged
);
  logic [DATA_W-1:0] mask;

  assign mask    = DATA_W'(1) << idx;
  assign bit_out = |(rdata & mask);
  assign merged  = set_val ? (rdata | mask) : (rdata & ~mask);
endmodule

// File: rtl/bb_rmw_ctrl.sv
module bb_rmw_ctrl
  import bb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_req,
  input  logic wr_q,
  input  logic m_ready,
  output logic cap_en,
  output logic data_en,
  output logic m_req,
  output logic m_write,
  output logic s_ready
);
  bb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (s_req)   state_d = ST_FETCH;
      ST_FETCH: if (m_ready) state_d = wr_q ? ST_STORE : ST_DONE;
      ST_STORE: if (m_ready) state_d = ST_DONE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cap_en  = (state_q == ST_IDLE) && s_req;
  assign data_en = (state_q == ST_FETCH) && m_ready;
  assign m_req   = (state_q == ST_FETCH) || (state_q == ST_STORE);
  assign m_write = (state_q == ST_STORE);
  assign s_ready = (state_q == ST_DONE);

  // R11: completion is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  // R8: a write-back only follows an acknowledged fetch, with no completion between
  p_store_follows_fetch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_write) |-> $past(m_req) && $past(m_ready) && !s_ready);
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter int          WIN_BITS = 25,
  parameter logic [31:0] BASE     = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_req,
  input  logic              s_write,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [1:0]        s_size,
  output logic              s_ready,
  output logic [DATA_W-1:0] s_rdata,
  output logic              m_req,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [1:0]        m_size,
  output logic [DATA_W-1:0] m_wdata,
  input  logic              m_ready,
  input  logic [DATA_W-1:0] m_rdata
);
  localparam int SHIFT = 5;
  localparam int IDX_W = $clog2(DATA_W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  bb_size_e          size_in;
  logic [ADDR_W-1:0] map_addr;
  logic [IDX_W-1:0]  map_idx;

  assign size_in = (s_size == 2'd3) ? SZ_WORD : bb_size_e'(s_size);

  bb_addr_map #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .SHIFT(SHIFT),
    .IDX_W(IDX_W), .BASE(BASE)
  ) u_map (
    .offset (s_addr[WIN_BITS-1:0]),
    .size   (size_in),
    .baddr  (map_addr),
    .bidx   (map_idx)
  );

  logic cap_en, data_en;
  logic wr_q, set_q, bit_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  bb_size_e          size_q;
  logic [DATA_W-1:0] merged_q;
  logic              merge_bit;
  logic [DATA_W-1:0] merge_data;

  bb_rmw_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .s_req   (s_req),
    .wr_q    (wr_q),
    .m_ready (m_ready),
    .cap_en  (cap_en),
    .data_en (data_en),
    .m_req   (m_req),
    .m_write (m_write),
    .s_ready (s_ready)
  );

  bb_bit_merge #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_merge (
    .rdata   (m_rdata),
    .idx     (idx_q),
    .set_val (set_q),
    .bit_out (merge_bit),
    .merged  (merge_data)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_q   <= 1'b0;
      set_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      size_q <= SZ_BYTE;
    end else if (cap_en) begin
      wr_q   <= s_write;
      set_q  <= s_wdata[0];
      addr_q <= map_addr;
      idx_q  <= map_idx;
      size_q <= size_in;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      bit_q    <= 1'b0;
      merged_q <= '0;
    end else if (data_en) begin
      bit_q    <= merge_bit;
      merged_q <= merge_data;
    end
  end

  assign m_addr  = addr_q;
  assign m_size  = size_q;
  assign m_wdata = merged_q;
  assign s_rdata = {{(DATA_W-1){1'b0}}, bit_q};

  logic unused_bits;
  assign unused_bits = ^{s_addr[ADDR_W-1:WIN_BITS], s_wdata[DATA_W-1:1]};

  // R3: halfword backing accesses are halfword aligned
  p_half_align_r3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m_req && m_size == 2'd1) |-> (m_addr[0] == 1'b0));

  // R4: word backing accesses are word aligned
  p_word_align_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m_req && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00));

  // R10: backing request held stable until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_write)));

  // R1: no backing or completion activity without a prior request
  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(m_req) |-> $past(s_req));
endmodule

// File: tb/tb_bitband_bridge.sv
`timescale 1ns/100ps
module tb_bitband_bridge;
  localparam logic [31:0] BASE = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        s_req, s_write;
  logic [31:0] s_addr, s_wdata;
  logic [1:0]  s_size;
  logic        s_ready;
  logic [31:0] s_rdata;
  logic        m_req, m_write;
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_ready;
  logic [31:0] m_rdata;

  always #2.5 clk = ~clk;

  bitband_bridge #(.BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_req(s_req), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_size(s_size), .s_ready(s_ready), .s_rdata(s_rdata),
    .m_req(m_req), .m_write(m_write), .m_addr(m_addr), .m_size(m_size),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0]  mem [256];
  logic [7:0]  expm [256];
  int          lat = 0;
  int          wcnt = 0;
  int          n_rd = 0, n_wr = 0;
  logic [31:0] rd_addr, wr_addr;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // backing memory model, little-endian, right-justified data
  always @(negedge clk) begin
    cycles++;
    if (m_ready) m_ready = 1'b0;
    else if (m_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        if (m_write) begin
          n_wr++; wr_addr = m_addr;
          mem[m_addr[7:0]] = m_wdata[7:0];
          if (m_size != 2'd0) mem[8'(m_addr[7:0] + 1)] = m_wdata[15:8];
          if (m_size == 2'd2) begin
            mem[8'(m_addr[7:0] + 2)] = m_wdata[23:16];
            mem[8'(m_addr[7:0] + 3)] = m_wdata[31:24];
          end
        end else begin
          n_rd++; rd_addr = m_addr;
          m_rdata = {24'h0, mem[m_addr[7:0]]};
          if (m_size != 2'd0) m_rdata[15:8] = mem[8'(m_addr[7:0] + 1)];
          if (m_size == 2'd2) begin
            m_rdata[23:16] = mem[8'(m_addr[7:0] + 2)];
            m_rdata[31:24] = mem[8'(m_addr[7:0] + 3)];
          end
        end
        m_ready = 1'b1;
      end
    end
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] exp_addr(input logic [24:0] off, input logic [1:0] sz);
    logic [31:0] a;
    a = BASE | 32'(off >> 5);
    if (sz == 2'd1) a[0] = 1'b0;
    if (sz >= 2'd2) a[1:0] = 2'b00;
    return a;
  endfunction

  // one bridge access; checks completion, master traffic and the model
  task automatic access(input bit wr, input logic [1:0] sz, input logic [24:0] off,
                        input bit val, input string tag, output logic [31:0] rd);
    int n;
    n = int'(off >> 2) & 11'h7ff;
    n_rd = 0; n_wr = 0;
    @(negedge clk);
    s_req = 1'b1; s_write = wr; s_size = sz; s_addr = 32'h2200_0000 | 32'(off);
    s_wdata = {31'h5a5a5a5a, val};
    do @(negedge clk); while (!s_ready);
    rd = s_rdata;
    s_req = 1'b0;
    @(negedge clk);
    chk(!s_ready, {tag, " R11 pulse"}, 32'(s_ready), 0);
    chk(n_rd == 1 && rd_addr == exp_addr(off, sz), {tag, " R2 R3 R4 fetch address"}, rd_addr, exp_addr(off, sz));
    if (wr) begin
      expm[n / 8][n % 8] = val;
      chk(n_wr == 1 && wr_addr == rd_addr, {tag, " R8 single write-back"}, 32'(n_wr), 1);
      for (int i = 0; i < 256; i++)
        if (mem[i] !== expm[i]) begin
          chk(1'b0, val ? {tag, " R6 set"} : {tag, " R7 clear"}, 32'(mem[i]), 32'(expm[i]));
          break;
        end
      checks++;
    end else begin
      chk(n_wr == 0, {tag, " R9 no write on read"}, 32'(n_wr), 0);
      chk(rd == {31'h0, expm[n / 8][n % 8]}, {tag, " R5 read bit"}, rd, {31'h0, expm[n / 8][n % 8]});
    end
  endtask

  task automatic t_reset;
    chk(!s_ready && !m_req, "R1 reset quiet", {s_ready, m_req}, 0);
    repeat (4) @(negedge clk);
    chk(!s_ready && !m_req, "R1 idle after release", {s_ready, m_req}, 0);
  endtask

  task automatic t_sweep(input logic [1:0] sz, input int first_byte, input int nbytes, input string tag);
    logic [31:0] rd;
    for (int b = first_byte * 8; b < (first_byte + nbytes) * 8; b++) begin
      access(1'b1, sz, 25'(b * 4), 1'b1, {tag, " set"}, rd);
      access(1'b0, sz, 25'(b * 4), 1'b0, {tag, " rd1"}, rd);
      access(1'b1, sz, 25'(b * 4), 1'b0, {tag, " clr"}, rd);
      access(1'b0, sz, 25'(b * 4), 1'b0, {tag, " rd0"}, rd);
    end
  endtask

  task automatic t_top_offset;
    logic [31:0] rd;
    access(1'b1, 2'd0, 25'h1ff_fffc, 1'b1, "R2 top byte", rd);
    access(1'b0, 2'd2, 25'h1ff_fffc, 1'b0, "R4 top word", rd);
    access(1'b1, 2'd3, 25'h1ff_ffa8, 1'b0, "R4 size3 word", rd);
    access(1'b0, 2'd1, 25'h1ff_ffa8, 1'b0, "R3 top half", rd);
  endtask

  initial begin
    rst_n = 1'b0; s_req = 1'b0; s_write = 1'b0; s_addr = '0; s_wdata = '0; s_size = '0;
    m_ready = 1'b0; m_rdata = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 5);
      expm[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_ready && !m_req, "R1 after reset release", {s_ready, m_req}, 0);
    t_sweep(2'd0, 0, 4, "R6 R7 byte");
    t_sweep(2'd1, 8, 4, "R3 half");
    t_sweep(2'd2, 16, 8, "R4 word");
    lat = 3;
    t_sweep(2'd2, 40, 4, "R10 word slow");
    t_sweep(2'd0, 50, 1, "R10 byte slow");
    lat = 0;
    t_top_offset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule